// File: doc/BRIEF.md
# Rotating Pairwise Slice Comparison Controller

This block sits around five identical 32-bit column slices of a four-column cipher round and gives it concurrent fault detection. Four slices are needed to carry the four columns, and the fifth is a spare. In every round cycle, exactly one adjacent pair of slices receives the same column. The results of that pair are compared. A mismatch latches a fault flag.

A three-bit schedule counter advances once per valid round cycle and steps through five pairings. The pairings are (4,3), (3,2), (2,1), (1,0) and (0,4), and the counter wraps back to the first. A single select vector is derived from the counter. It steers the four column inputs onto the five slices and picks the slice result for each column output. Over one ten-round encryption, each pairing is used twice and each slice is compared four times. The slice contents are outside this block: it drives the per-slice input buses and reads back the per-slice result buses.

Top module: `rot_pair_check`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, `fault` becomes 0 and the schedule returns to pairing 0.
- R2: The source column of each slice input (slices 0..4) is fixed per pairing. Pairing 0 uses columns 0,1,2,3,3. Pairing 1 uses 0,1,2,2,3. Pairing 2 uses 0,1,1,2,3. Pairing 3 uses 0,0,1,2,3. Pairing 4 uses 0,1,2,3,0. Here column c is `col_in[32c+31:32c]` and slice s is `slice_in[32s+31:32s]`.
- R3: Each column output `col_out[32c+31:32c]` carries the result of a slice that was fed column c in the current pairing. The outputs are combinational from the slice results.
- R4: The pairing advances by one on each clock edge where `round_vld` is high and wraps from 4 to 0. It holds when `round_vld` is low.
- R5: Pairing p watches slices (4-p, 3-p) for p<4, and slices (0, 4) for p=4. If those two results differ at an edge with `round_vld` high, `fault` is 1 after that edge.
- R6: A result mismatch between slices that do not form the watched pair has no effect on `fault`.
- R7: A mismatch at an edge with `round_vld` low has no effect on `fault`.
- R8: Once set, `fault` stays 1 until reset.
- R9: A slice whose result is stuck in a way that changes it is flagged within five valid round cycles, whatever pairing the schedule is in when the fault appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| round_vld | input | 1 | A round is computed this cycle |
| col_in | input | 128 | Four column words, column c in bits 32c+31:32c |
| col_out | output | 128 | Four column results, same layout |
| slice_in | output | 160 | Input word for each of the five slices |
| slice_out | input | 160 | Result word returned by each of the five slices |
| fault | output | 1 | Sticky mismatch flag |

## Verification
Two functions can act on the same edge: a mismatch on the watched pair, and the schedule wrapping from pairing 4 back to pairing 0. This happens when slice 0 or slice 4 is faulty and the stuck fault is injected while pairing 4 is active. The stuck-bit sweep, which covers every slice and every starting pairing, creates exactly that case. It is judged by two things. First, `fault` must be high after the edge. Second, the slice input routing seen on the next cycle must match pairing 0. A second collision, a mismatch on a pair that is not watched in the same cycle as clean watched results, is forced by corrupting a single slice that lies outside the watched pair.

// File: rtl/rot_pair_check.sv
module rot_pair_check #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           round_vld,
  input  logic [4*W-1:0] col_in,
  output logic [4*W-1:0] col_out,
  output logic [5*W-1:0] slice_in,
  input  logic [5*W-1:0] slice_out,
  output logic           fault
);
  localparam int NC   = 4;
  localparam int NS   = NC + 1;
  localparam int CW   = $clog2(NS);
  localparam logic [CW-1:0] LAST = CW'(NS - 1);

  logic [CW-1:0] cfg;
  logic [NC:1]   own;
  logic [NS-1:0] eq;
  logic [7:0]    eq_x;
  logic [CW-1:0] sel;
  logic          eq_sel;

  assign slice_in[0 +: W] = col_in[0 +: W];

  for (genvar j = 1; j <= NC; j++) begin : g_up
    assign own[j] = (cfg != LAST) && ((CW'(j) + cfg) >= LAST);
    assign slice_in[j*W +: W] = own[j] ? col_in[(j-1)*W +: W]
                                       : col_in[(j%NC)*W +: W];
  end

  for (genvar c = 0; c < NC; c++) begin : g_dn
    assign col_out[c*W +: W] = own[c+1] ? slice_out[(c+1)*W +: W]
                                        : slice_out[c*W +: W];
  end

  for (genvar k = 0; k < NS; k++) begin : g_eq
    assign eq[k] = slice_out[k*W +: W] == slice_out[((k+NS-1)%NS)*W +: W];
    AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (rst)
      (sel == CW'(k)) |-> slice_in[k*W +: W] == slice_in[((k+NS-1)%NS)*W +: W]); // R2
  end

  assign sel    = LAST - cfg;
  assign eq_x   = 8'(eq);
  assign eq_sel = eq_x[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      fault <= 1'b0;
    end else if (round_vld) begin
      cfg <= (cfg == LAST) ? '0 : cfg + 1'b1;
      if (!eq_sel) fault <= 1'b1;
    end
  end

  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (rst) cfg <= LAST); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !round_vld |=> $stable(cfg)); // R4
  AST_CFG_WRAP: assert property (@(posedge clk) disable iff (rst)
    (round_vld && cfg == LAST) |=> cfg == '0); // R4
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    (round_vld && !eq_sel) |=> fault); // R5
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!fault && !(round_vld && !eq_sel)) |=> !fault); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault); // R8
endmodule

// File: tb/tb_rot_pair_check.sv
module tb_rot_pair_check;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic           clk = 0;
  logic           rst = 1;
  logic           round_vld = 0;
  logic [4*W-1:0] col_in = '0;
  logic [4*W-1:0] col_out;
  logic [5*W-1:0] slice_in;
  logic [5*W-1:0] slice_out;
  logic           fault;

  int n_chk = 0, n_fail = 0;
  int exp_cfg = 0;
  int inj_slice = -1;
  int inj_mode = 0;
  bit done = 0;

  rot_pair_check #(.W(W)) dut (
    .clk(clk), .rst(rst), .round_vld(round_vld), .col_in(col_in),
    .col_out(col_out), .slice_in(slice_in), .slice_out(slice_out), .fault(fault));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [W-1:0] fn(input logic [W-1:0] x);
    return {x[23:0], x[31:24]} ^ 32'h5a5a_0f0f;
  endfunction

  always_comb begin
    for (int k = 0; k < 5; k++) begin
      slice_out[k*W +: W] = fn(slice_in[k*W +: W]);
      if (k == inj_slice && inj_mode == 1) slice_out[k*W +: W] = slice_out[k*W +: W] ^ 32'h0000_0100;
      if (k == inj_slice && inj_mode == 2) slice_out[k*W +: W] = slice_out[k*W +: W] | 32'h1;
    end
  end

  // source column per slice, {s4,s3,s2,s1,s0}, two bits each
  localparam logic [9:0] SRC [5] = '{10'b11_11_10_01_00, 10'b11_10_10_01_00,
                                     10'b11_10_01_01_00, 10'b11_10_01_00_00,
                                     10'b00_11_10_01_00};

  function automatic logic [5*W-1:0] exp_route(input int cfg, input logic [4*W-1:0] c);
    logic [5*W-1:0] r;
    for (int s = 0; s < 5; s++) r[s*W +: W] = c[32'(SRC[cfg][2*s +: 2])*W +: W];
    return r;
  endfunction

  function automatic logic [4*W-1:0] exp_cols(input logic [4*W-1:0] c);
    logic [4*W-1:0] r;
    for (int k = 0; k < 4; k++) r[k*W +: W] = fn(c[k*W +: W]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [5*W-1:0] act, input logic [5*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [4*W-1:0] c, input bit v);
    @(negedge clk);
    col_in = c;
    round_vld = v;
    #1;
    chk(slice_in == exp_route(exp_cfg, c), "R2 R4 routing", slice_in, exp_route(exp_cfg, c));
    if (inj_mode == 0)
      chk(col_out == exp_cols(c), "R3 column out", 160'(col_out), 160'(exp_cols(c)));
    @(posedge clk);
    #1;
    if (v) exp_cfg = (exp_cfg + 1) % 5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    round_vld = 0;
    @(posedge clk);
    #1;
    rst = 0;
    exp_cfg = 0;
  endtask

  localparam logic [4*W-1:0] VCOL [8] = '{
    {32'h0000_0004, 32'h0000_0003, 32'h0000_0002, 32'h0000_0001},
    {32'hdead_beef, 32'h1234_5678, 32'hcafe_f00d, 32'h0bad_c0de},
    {32'hffff_ffff, 32'h0000_0000, 32'hffff_ffff, 32'h0000_0000},
    {32'h8000_0001, 32'h4000_0002, 32'h2000_0004, 32'h1000_0008},
    {32'h0f0f_0f0f, 32'hf0f0_f0f0, 32'h3333_3333, 32'hcccc_cccc},
    {32'h0102_0304, 32'h0506_0708, 32'h090a_0b0c, 32'h0d0e_0f10},
    {32'h7777_0000, 32'h0000_7777, 32'h5555_aaaa, 32'haaaa_5555},
    {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888}};
  localparam bit VVLD [8] = '{1, 1, 0, 1, 1, 1, 1, 1};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fault == 1'b0, "R1 fault after reset", 160'(fault), 160'(0));
    chk(slice_in == exp_route(0, col_in), "R1 pairing 0 after reset", slice_in, exp_route(0, col_in));
    rst = 0;

    for (int i = 0; i < 8; i++) begin
      cycle(VCOL[i], VVLD[i]);
      chk(fault == 1'b0, "R5 clean run", 160'(fault), 160'(0));
    end

    do_reset();
    inj_slice = 4; inj_mode = 1;
    cycle(VCOL[1], 0);
    chk(fault == 1'b0, "R7 mismatch without round strobe", 160'(fault), 160'(0));
    inj_slice = 1;
    cycle(VCOL[1], 1);
    chk(fault == 1'b0, "R6 mismatch on unwatched pair", 160'(fault), 160'(0));
    inj_slice = 2;
    cycle(VCOL[2], 1);
    chk(fault == 1'b1, "R5 mismatch on watched pair", 160'(fault), 160'(1));
    inj_mode = 0; inj_slice = -1;
    repeat (3) cycle(VCOL[3], 1);
    chk(fault == 1'b1, "R8 fault held", 160'(fault), 160'(1));
    do_reset();
    chk(fault == 1'b0, "R8 R1 reset clears fault", 160'(fault), 160'(0));

    for (int b = 0; b < 5; b++) begin
      for (int st = 0; st < 5; st++) begin
        int n;
        do_reset();
        for (int a = 0; a < st; a++) cycle({32'h0100_0001, 32'h0100_0002, 32'h0100_0003, 32'h0100_0004}, 1);
        inj_slice = b; inj_mode = 2;
        n = 0;
        while (!fault && n < 6) begin
          cycle({32'h0100_00a0, 32'h01ff_00b0, 32'h0122_00c0, 32'h0133_00d0}, 1);
          n++;
        end
        chk(fault == 1'b1 && n <= 5, $sformatf("R9 stuck slice %0d from pairing %0d", b, st),
            160'(n), 160'(5));
        inj_mode = 0; inj_slice = -1;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule